// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and walks the memory from reset to a usable state. While reset is held it deselects the device and keeps clock enable low. Once reset is released it raises clock enable and holds NOP for a long settling pause. It then closes every bank with one precharge-all command, issues a pair of auto-refresh commands and programs the mode register. Each command is followed by its own recovery gap. When the last gap has elapsed it raises a ready flag, and the normal traffic logic can take over the command pins.

All delays are parameters given in clock cycles, so one build serves any clock rate. The mode word comes in on a configuration input. The reserved and operating-mode bits are cleared before the word is placed on the address bus. If the configured CAS latency is not one the device accepts, the sequencer raises a sticky error flag instead of loading the mode register and idles on NOP until the next reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low: cke_o is 0, cs_n_o is 1, ready_o is 0 and error_o is 0.
- R2: cke_o is 1 from the first clock edge after reset release until reset is asserted again.
- R3: On every post-reset cycle that carries no other command, the pins {cs_n,ras_n,cas_n,we_n} show NOP = 0111, and addr_o and ba_o are 0.
- R4: Cycle n counts the rising edges since reset release. Cycles 1..PAUSE_CYC carry only NOP. Cycle PAUSE_CYC+1 carries precharge-all: pins 0010, addr_o[10]=1, all other address bits 0.
- R5: The first auto-refresh (pins 0001) comes exactly T_RP cycles after the precharge.
- R6: The second auto-refresh comes exactly T_RFC cycles after the first. No further refresh is issued.
- R7: The mode load (pins 0000, ba_o=0) comes T_RFC cycles after the second refresh. addr_o equals the configured word with bits 11, 10, 8 and 7 forced to 0 and the other bits passed through.
- R8: ready_o rises exactly T_MRD cycles after the mode load. It then stays 1 with NOP on the pins.
- R9: If configured bits 6:4 are neither 010 nor 011, no mode load is issued. error_o rises in the cycle where the load would have come and stays 1. ready_o stays 0 and the pins stay at NOP.
- R10: Asserting reset at any point aborts the sequence. After release, the full sequence restarts from the pause with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_cfg_i | input | ADDR_W | Configured mode word, held stable during startup |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | BA_W | Bank address |
| ready_o | output | 1 | Startup finished, device usable |
| error_o | output | 1 | Illegal CAS latency configured, sequence halted |

## Verification
The bench predicts the command, address and flags for every cycle of each run and compares them at the ports. An off-by-one in any gap therefore shows up as a command in the wrong cycle, or as a third refresh or a missing one. A mode word with all bits set catches a design that passes reserved bits through to the address bus. Both illegal CAS edge codes, 000 and 111, are applied, and a design that skipped the legality check would load the mode register and raise ready. A reset in the middle of the refresh pair catches a sequencer that resumes where it stopped instead of restarting the pause.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_DESEL = 4'b1111;
  localparam cmd_t CMD_NOP   = 4'b0111;
  localparam cmd_t CMD_PRE   = 4'b0010;
  localparam cmd_t CMD_REF   = 4'b0001;
  localparam cmd_t CMD_MRS   = 4'b0000;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF1,
    ST_WAIT_RF1,
    ST_REF2,
    ST_WAIT_RF2,
    ST_MRS,
    ST_WAIT_MRD,
    ST_READY,
    ST_ERROR
  } state_e;

  function automatic logic cas_legal(input logic [2:0] cl);
    return (cl == 3'd2) || (cl == 3'd3);
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= W'(RST_VAL);
    else if (load_i)         cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_mode_fmt.sv
module sdram_mode_fmt
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] cfg_i,
  output logic [ADDR_W-1:0] word_o,
  output logic              legal_o
);

  localparam int unsigned RSV_LO = 10;

  always_comb begin
    word_o = cfg_i;
    for (int i = RSV_LO; i < ADDR_W; i++) word_o[i] = 1'b0;
    word_o[8:7] = 2'b00;  // standard operating mode
  end

  assign legal_o = cas_legal(cfg_i[6:4]);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned PAUSE_CYC = 10000,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RFC     = 9,
  parameter int unsigned T_MRD     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_cfg_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ready_o,
  output logic              error_o
);

  localparam int unsigned AP_BIT  = 10;
  localparam int unsigned DLY_MAX = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                                   : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int unsigned MAX_CNT = (PAUSE_CYC > DLY_MAX) ? PAUSE_CYC : DLY_MAX;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  state_e             state_q, state_d;
  logic               cke_q;
  logic               ld;
  logic [CNT_W-1:0]   ld_val;
  logic               done;
  logic [ADDR_W-1:0]  mode_word;
  logic               mode_ok;
  cmd_t               cmd;

  sdram_init_timer #(
    .W      (CNT_W),
    .RST_VAL(PAUSE_CYC - 1)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cke_q),
    .load_i    (ld),
    .load_val_i(ld_val),
    .done_o    (done)
  );

  sdram_mode_fmt #(
    .ADDR_W(ADDR_W)
  ) i_fmt (
    .cfg_i  (mode_cfg_i),
    .word_o (mode_word),
    .legal_o(mode_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      cke_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cke_q   <= 1'b1;
    end
  end

  // command states load delay-2 so the wait state spans delay-1 cycles
  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_PAUSE:    if (cke_q && done) state_d = ST_PRE;
      ST_PRE:      begin ld = 1'b1; ld_val = CNT_W'(T_RP - 2);  state_d = ST_WAIT_RP;  end
      ST_WAIT_RP:  if (done) state_d = ST_REF1;
      ST_REF1:     begin ld = 1'b1; ld_val = CNT_W'(T_RFC - 2); state_d = ST_WAIT_RF1; end
      ST_WAIT_RF1: if (done) state_d = ST_REF2;
      ST_REF2:     begin ld = 1'b1; ld_val = CNT_W'(T_RFC - 2); state_d = ST_WAIT_RF2; end
      ST_WAIT_RF2: if (done) state_d = mode_ok ? ST_MRS : ST_ERROR;
      ST_MRS:      begin ld = 1'b1; ld_val = CNT_W'(T_MRD - 2); state_d = ST_WAIT_MRD; end
      ST_WAIT_MRD: if (done) state_d = ST_READY;
      ST_READY:    state_d = ST_READY;
      ST_ERROR:    state_d = ST_ERROR;
      default:     state_d = ST_ERROR;
    endcase
  end

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    unique case (state_q)
      ST_PRE:          begin cmd = CMD_PRE; addr_o[AP_BIT] = 1'b1; end
      ST_REF1, ST_REF2: cmd = CMD_REF;
      ST_MRS:          begin cmd = CMD_MRS; addr_o = mode_word; end
      default:         cmd = CMD_NOP;
    endcase
    if (!cke_q) begin
      cmd    = CMD_DESEL;
      addr_o = '0;
    end
  end

  assign cke_o   = cke_q;
  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign ba_o    = '0;
  assign ready_o = (state_q == ST_READY);
  assign error_o = (state_q == ST_ERROR);

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BA_W-1:0]   ba_o,
  input logic              ready_o,
  input logic              error_o
);

  logic [3:0] pins;
  logic       is_nop, is_pre, is_mrs;
  assign pins   = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_nop = (pins == 4'b0111);
  assign is_pre = (pins == 4'b0010);
  assign is_mrs = (pins == 4'b0000);

  AST_RESET_DESEL: assert property (@(posedge clk_i) !rst_ni |-> (cs_n_o && !cke_o)); // R1
  AST_CKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !$fell(cke_o)); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni) is_pre |-> addr_o[10]); // R4
  AST_MODE_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> (addr_o[11:10] == 2'b00 && addr_o[8:7] == 2'b00 && ba_o == '0)); // R7
  AST_MODE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni) is_mrs |=> is_nop); // R7
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) ready_o |=> ready_o); // R8
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) ready_o |-> is_nop); // R8
  AST_MODE_CAS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> (addr_o[6:4] == 3'd2 || addr_o[6:4] == 3'd3)); // R9
  AST_ERROR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!ready_o && is_nop)); // R9
  AST_ERROR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) error_o |=> error_o); // R9

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W(ADDR_W),
  .BA_W  (BA_W)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cke_o  (cke_o),
  .cs_n_o (cs_n_o),
  .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o),
  .we_n_o (we_n_o),
  .addr_o (addr_o),
  .ba_o   (ba_o),
  .ready_o(ready_o),
  .error_o(error_o)
);

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int PAUSE  = 40;
  localparam int RP     = 3;
  localparam int RFC    = 6;
  localparam int MRD    = 2;
  localparam int N_PRE  = PAUSE + 1;
  localparam int N_R1   = N_PRE + RP;
  localparam int N_R2   = N_R1 + RFC;
  localparam int N_MRS  = N_R2 + RFC;
  localparam int N_RDY  = N_MRS + MRD;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] mode_cfg_i = '0;
  logic              cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ready_o, error_o;
  logic [ADDR_W-1:0] addr_o;
  logic [BA_W-1:0]   ba_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .PAUSE_CYC(PAUSE),
    .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD)
  ) i_sdram_init_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_cfg_i(mode_cfg_i),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .addr_o(addr_o), .ba_o(ba_o),
    .ready_o(ready_o), .error_o(error_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic legal_cl(input logic [ADDR_W-1:0] cfg);
    return cfg[6:4] == 3'b010 || cfg[6:4] == 3'b011;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_word(input logic [ADDR_W-1:0] cfg);
    logic [ADDR_W-1:0] w;
    w = cfg;
    w[11:10] = 2'b00;
    w[8:7]   = 2'b00;
    return w;
  endfunction

  function automatic logic [3:0] exp_pins(input int n, input logic ok);
    if (n == N_PRE) return 4'b0010;
    if (n == N_R1 || n == N_R2) return 4'b0001;
    if (n == N_MRS && ok) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input int n, input logic [ADDR_W-1:0] cfg);
    if (n == N_PRE) return ADDR_W'(1) << 10;
    if (n == N_MRS && legal_cl(cfg)) return exp_word(cfg);
    return '0;
  endfunction

  function automatic string tag_of(input int n, input logic ok);
    if (n <= N_PRE) return "R4";
    if (n == N_R1) return "R5";
    if (n == N_R2) return "R6";
    if (n == N_MRS) return ok ? "R7" : "R9";
    if (n > N_MRS) return ok ? "R8" : "R9";
    return "R3";
  endfunction

  // reset, then check every cycle up to stop_n; pre prefixes tags for the restart case
  task automatic run_seq(input logic [ADDR_W-1:0] cfg, input int stop_n, input string pre);
    logic ok;
    ok = legal_cl(cfg);
    @(negedge clk_i);
    rst_ni = 1'b0;
    mode_cfg_i = cfg;
    #1;
    chk("R1", "cke in reset", 32'(cke_o), 0);
    chk("R1", "cs_n in reset", 32'(cs_n_o), 1);
    chk("R1", "ready/error in reset", 32'({ready_o, error_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 1; n <= stop_n; n++) begin
      @(negedge clk_i);
      chk({pre, "R2"}, "cke", 32'(cke_o), 1);
      chk({pre, tag_of(n, ok)}, $sformatf("pins n=%0d", n),
          32'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 32'(exp_pins(n, ok)));
      chk({pre, tag_of(n, ok)}, $sformatf("addr n=%0d", n), 32'(addr_o), 32'(exp_addr(n, cfg)));
      chk({pre, "R3"}, "ba", 32'(ba_o), 0);
      chk({pre, (ok ? "R8" : "R9")}, $sformatf("ready n=%0d", n), 32'(ready_o), 32'(ok && n >= N_RDY));
      chk({pre, "R9"}, $sformatf("error n=%0d", n), 32'(error_o), 32'(!ok && n >= N_MRS));
    end
  endtask

  initial begin
    logic [ADDR_W-1:0] c;
    void'($urandom(32'h5D2A1));
    // directed: reserved bits all set, CAS 3
    run_seq(12'hFBF, N_RDY + 4, "");
    // directed: CAS 2, all else clear
    run_seq(12'h020, N_RDY + 4, "");
    // directed illegal CAS codes at both ends
    run_seq(12'h003, N_RDY + 4, "");
    run_seq(12'h070, N_RDY + 4, "");
    // R10: abort between the refreshes, then a full restart
    run_seq(12'h032, N_R1 + 2, "");
    run_seq(12'h032, N_RDY + 4, "R10/");
    // random legal words
    for (int k = 0; k < 5; k++) begin
      c = ADDR_W'($urandom);
      c[6:4] = ($urandom % 2) ? 3'b011 : 3'b010;
      run_seq(c, N_RDY + 3, "");
    end
    // random unconstrained words
    for (int k = 0; k < 4; k++) begin
      c = ADDR_W'($urandom);
      run_seq(c, N_RDY + 3, "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule